// File: doc/BRIEF.md
# Clock Source Switch Controller

This block sequences a change of the system clock between four oscillators: the fast internal RC (with or without its PLL), the primary oscillator (with or without its PLL), the secondary oscillator and the low-power internal RC. Software writes a 3-bit requested-source code and then sets a start bit. The block first screens the request. It drops the request at once if the request names the current source, uses a reserved code, or moves directly between the two PLL modes. If the request passes, the block clears the PLL-lock and clock-fail status bits and switches on the target oscillator. It then waits for the crystal start-up timer and for PLL lock, as the target needs.

Once the target is ready, a counter in the target's own clock domain waits for a fixed number of its rising edges. The counter's done flag crosses back through a synchronizer. The block then moves the current-source code, which also drives the clock multiplexer, to the target and clears the start bit. After the switch the old oscillator is switched off. The low-power RC stays on while the watchdog or clock monitor needs it, and the secondary oscillator stays on while its keep-alive enable is set. A configuration input can freeze the block on its reset-default source.

The clock of the pending target reaches the block on `pend_clk` through an outside pre-multiplexer that `pend_sel` steers.

Top module: `clksw_ctrl`

## Requirements
- R1: During reset and directly after it, `cur_src` equals `cfg_def_src`, and `start_bit`, `lock_stat` and `fail_stat` are 0.
- R2: While `cfg_sw_dis` is 1, `start_bit` reads 0 one clock later, `cur_src` follows `cfg_def_src` one clock later, and `start_set` and the requested code change nothing.
- R3: A request equal to the current source is dropped: `start_bit` is back at 0 two clock edges after the `start_set` cycle, and `cur_src` is unchanged.
- R4: The reserved codes 110 and 111 are dropped in the same way as R3. The valid codes are 000 internal RC, 001 internal RC with PLL, 010 primary, 011 primary with PLL, 100 secondary and 101 low-power RC.
- R5: A direct request between 001 and 011, in either direction, is dropped in the same way as R3.
- R6: `fail_evt` sets `fail_stat`. When a valid request is accepted, `lock_stat` and `fail_stat` are cleared in the same edge.
- R7: While a switch is pending, the target's enable in `osc_en` is 1 (bit 0 internal RC, bit 1 primary, bit 2 secondary, bit 3 low-power RC), and `pll_en` is 1 for a PLL target.
- R8: `cur_src` does not change while the target waits for `ost_done` (needed by code 100, and by 010 and 011 when `posc_xtal` is 1) or for `pll_lock` (needed by 001 and 011).
- R9: Once the target is ready, at least SETTLE_CYC rising edges of `pend_clk` pass before `cur_src` takes the requested code. `start_bit` clears at the same time.
- R10: After a switch, `osc_en` has exactly the bit of the new source set, plus bit 3 while `wdt_fscm_on` is 1 and bit 2 while `sosc_keep` is 1.
- R11: `lock_stat` becomes 1 when `pll_lock` is high while a PLL source is in use or pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sw_dis | input | 1 | Configuration: switching disabled |
| cfg_def_src | input | 3 | Configuration: reset-default source code |
| posc_xtal | input | 1 | Configuration: primary oscillator is a crystal |
| wr_req | input | 1 | Write strobe for the requested-source field |
| req_wdata | input | 3 | Requested-source code to write |
| start_set | input | 1 | Write 1 to the start bit |
| fail_evt | input | 1 | Clock-fail event from the clock monitor |
| ost_done | input | 1 | Oscillator start-up timer expired |
| pll_lock | input | 1 | PLL lock indication |
| wdt_fscm_on | input | 1 | Watchdog or clock monitor enabled |
| sosc_keep | input | 1 | Secondary oscillator keep-alive enable |
| pend_clk | input | 1 | Clock of the pending target source |
| req_src | output | 3 | Requested-source field |
| start_bit | output | 1 | Start bit, cleared by hardware |
| cur_src | output | 3 | Current source status and clock multiplexer select |
| pend_sel | output | 3 | Target code steering the pre-multiplexer for `pend_clk` |
| lock_stat | output | 1 | PLL lock status |
| fail_stat | output | 1 | Clock-fail status |
| osc_en | output | 4 | Per-oscillator enables |
| pll_en | output | 1 | PLL enable |

## Verification
Dropped requests are due at a fixed point: the start bit is set on the first edge after the `start_set` cycle and cleared on the second. The bench samples the start bit on the falling edge after each of these edges. Switch-related enables and cleared status bits are sampled a few cycles into the wait, while the bench still holds the ready inputs low. A completed switch crosses two clock domains, so its latency varies. The bench therefore polls on falling edges until the start bit clears, counts `pend_clk` rising edges from the moment it raises readiness, and checks the new source, the edge count and the enables at that point. Requests are spaced a dozen cycles apart so that the previous done flag has returned to 0.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
   localparam int SRC_W   = 3;
   localparam int NUM_OSC = 4;

   localparam logic [SRC_W-1:0] SRC_FRC    = 3'b000;
   localparam logic [SRC_W-1:0] SRC_FRCPLL = 3'b001;
   localparam logic [SRC_W-1:0] SRC_PRI    = 3'b010;
   localparam logic [SRC_W-1:0] SRC_PRIPLL = 3'b011;
   localparam logic [SRC_W-1:0] SRC_SEC    = 3'b100;
   localparam logic [SRC_W-1:0] SRC_LPRC   = 3'b101;

   localparam logic [SRC_W-1:0] OSC_FRC  = 3'd0;
   localparam logic [SRC_W-1:0] OSC_PRI  = 3'd1;
   localparam logic [SRC_W-1:0] OSC_SEC  = 3'd2;
   localparam logic [SRC_W-1:0] OSC_LPRC = 3'd3;
   localparam logic [SRC_W-1:0] OSC_NONE = 3'd7;

   typedef enum logic [1:0] {ST_IDLE, ST_WAKE, ST_SETTLE} sw_state_t;

   function automatic logic code_valid(logic [SRC_W-1:0] c);
      return c <= SRC_LPRC;
   endfunction

   function automatic logic code_pll(logic [SRC_W-1:0] c);
      return (c == SRC_FRCPLL) || (c == SRC_PRIPLL);
   endfunction

   function automatic logic [SRC_W-1:0] osc_of(logic [SRC_W-1:0] c);
      case (c)
         SRC_FRC, SRC_FRCPLL: return OSC_FRC;
         SRC_PRI, SRC_PRIPLL: return OSC_PRI;
         SRC_SEC:             return OSC_SEC;
         SRC_LPRC:            return OSC_LPRC;
         default:             return OSC_NONE;
      endcase
   endfunction

   function automatic logic pll_cross(logic [SRC_W-1:0] a, logic [SRC_W-1:0] b);
      return code_pll(a) && code_pll(b) && (a != b);
   endfunction
endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("clksw_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] ff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= '0;
      else        ff <= {ff[STAGES-2:0], d};
   end

   assign q = ff[STAGES-1];
endmodule

// File: rtl/clksw_settle.sv
module clksw_settle #(
   parameter int SETTLE_CYC  = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic new_clk,
   input  logic rst_n,
   input  logic go,
   output logic done
);
   localparam int CNT_W = $clog2(SETTLE_CYC + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETTLE_CYC);

   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("clksw_settle: SETTLE_CYC must be at least 1");
   end

   logic             go_s;
   logic [CNT_W-1:0] cnt;

   clksw_sync #(.STAGES(SYNC_STAGES)) u_go_sync (
      .clk(new_clk), .rst_n(rst_n), .d(go), .q(go_s)
   );

   always_ff @(posedge new_clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (!go_s)         cnt <= '0;
      else if (cnt != LIMIT)  cnt <= cnt + 1'b1;
   end

   assign done = (cnt == LIMIT);

   // R9
   settle_cap_chk: assert property (@(posedge new_clk) disable iff (!rst_n)
      (cnt != LIMIT && go_s) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
   import clksw_pkg::*;
#(
   parameter int SETTLE_CYC  = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_sw_dis,
   input  logic [SRC_W-1:0]    cfg_def_src,
   input  logic                posc_xtal,
   input  logic                wr_req,
   input  logic [SRC_W-1:0]    req_wdata,
   input  logic                start_set,
   input  logic                fail_evt,
   input  logic                ost_done,
   input  logic                pll_lock,
   input  logic                wdt_fscm_on,
   input  logic                sosc_keep,
   input  logic                pend_clk,
   output logic [SRC_W-1:0]    req_src,
   output logic                start_bit,
   output logic [SRC_W-1:0]    cur_src,
   output logic [SRC_W-1:0]    pend_sel,
   output logic                lock_stat,
   output logic                fail_stat,
   output logic [NUM_OSC-1:0]  osc_en,
   output logic                pll_en
);
   sw_state_t        state;
   logic [SRC_W-1:0] cur_q, req_q, tgt_q;
   logic             start_q, lock_q, fail_q, go_q;
   logic             done_raw, done_s;
   logic             busy, req_legal, needs_ost, ready, pll_in_use;

   clksw_settle #(.SETTLE_CYC(SETTLE_CYC), .SYNC_STAGES(SYNC_STAGES)) u_settle (
      .new_clk(pend_clk), .rst_n(rst_n), .go(go_q), .done(done_raw)
   );

   clksw_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
      .clk(clk), .rst_n(rst_n), .d(done_raw), .q(done_s)
   );

   assign busy       = (state != ST_IDLE);
   assign req_legal  = code_valid(req_q) && (req_q != cur_q) && !pll_cross(cur_q, req_q);
   assign needs_ost  = (tgt_q == SRC_SEC) ||
                       (posc_xtal && (osc_of(tgt_q) == OSC_PRI));
   assign ready      = (!needs_ost || ost_done) && (!code_pll(tgt_q) || pll_lock);
   assign pll_in_use = busy ? code_pll(tgt_q) : code_pll(cur_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cur_q   <= cfg_def_src;
         req_q   <= cfg_def_src;
         tgt_q   <= cfg_def_src;
         start_q <= 1'b0;
         lock_q  <= 1'b0;
         fail_q  <= 1'b0;
         go_q    <= 1'b0;
      end else begin
         if (wr_req)                 req_q  <= req_wdata;
         if (fail_evt)               fail_q <= 1'b1;
         if (pll_lock && pll_in_use) lock_q <= 1'b1;
         if (cfg_sw_dis) begin
            cur_q   <= cfg_def_src;
            start_q <= 1'b0;
            go_q    <= 1'b0;
            state   <= ST_IDLE;
         end else begin
            case (state)
               ST_IDLE: begin
                  if (start_q && !done_s) begin
                     if (req_legal) begin
                        tgt_q  <= req_q;
                        lock_q <= 1'b0;
                        fail_q <= 1'b0;
                        state  <= ST_WAKE;
                     end else begin
                        start_q <= 1'b0;
                     end
                  end else if (start_set) begin
                     start_q <= 1'b1;
                  end
               end
               ST_WAKE: begin
                  if (ready) begin
                     go_q  <= 1'b1;
                     state <= ST_SETTLE;
                  end
               end
               ST_SETTLE: begin
                  if (done_s) begin
                     cur_q   <= tgt_q;
                     start_q <= 1'b0;
                     go_q    <= 1'b0;
                     state   <= ST_IDLE;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   for (genvar p = 0; p < NUM_OSC; p++) begin : g_osc_en
      localparam logic [SRC_W-1:0] IDX = SRC_W'(p);
      localparam bit KEEP_LPRC = (IDX == OSC_LPRC);
      localparam bit KEEP_SEC  = (IDX == OSC_SEC);
      assign osc_en[p] = (osc_of(cur_q) == IDX) ||
                         (busy && osc_of(tgt_q) == IDX) ||
                         (KEEP_LPRC && wdt_fscm_on) ||
                         (KEEP_SEC && sosc_keep);
   end

   assign pll_en    = code_pll(cur_q) || (busy && code_pll(tgt_q));
   assign req_src   = req_q;
   assign start_bit = start_q;
   assign cur_src   = cur_q;
   assign pend_sel  = tgt_q;
   assign lock_stat = lock_q;
   assign fail_stat = fail_q;

   // R2
   dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_sw_dis |=> (!start_bit && cur_src == $past(cfg_def_src)));
   // R3
   redundant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start_q && !done_s && !cfg_sw_dis && req_q == cur_q)
      |=> (!start_q && $stable(cur_q)));
   // R4
   reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start_q && !done_s && !cfg_sw_dis && !code_valid(req_q))
      |=> (!start_q && state == ST_IDLE));
   // R5
   cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && start_q && !done_s && !cfg_sw_dis && pll_cross(cur_q, req_q))
      |=> (!start_q && $stable(cur_q)));
   // R6
   clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAKE && $past(state) == ST_IDLE) |-> (!lock_q && !fail_q));
   // R8
   wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAKE && !ready && !cfg_sw_dis) |=> (state == ST_WAKE && $stable(cur_q)));
   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_sw_dis && state != ST_SETTLE) |=> $stable(cur_q));
endmodule

// File: tb/clksw_ctrl_test.sv
module clksw_ctrl_test;
   localparam int SETTLE = 10;

   logic       clk = 1'b0, pend_clk = 1'b0, rst_n = 1'b0;
   logic       cfg_sw_dis = 1'b0, posc_xtal = 1'b0;
   logic [2:0] cfg_def_src = 3'b000, req_wdata = 3'b000;
   logic       wr_req = 1'b0, start_set = 1'b0, fail_evt = 1'b0;
   logic       ost_done = 1'b0, pll_lock = 1'b0, wdt_fscm_on = 1'b0, sosc_keep = 1'b0;
   logic [2:0] req_src, cur_src, pend_sel;
   logic       start_bit, lock_stat, fail_stat, pll_en;
   logic [3:0] osc_en;

   int n_chk = 0, n_fail = 0, pend_cnt = 0;
   bit counting = 1'b0, finished = 1'b0;
   logic [2:0] cur_model = 3'b000;

   always #5 clk = ~clk;
   always #7 pend_clk = ~pend_clk;
   always @(posedge pend_clk) if (counting) pend_cnt <= pend_cnt + 1;

   clksw_ctrl #(.SETTLE_CYC(SETTLE), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_sw_dis(cfg_sw_dis), .cfg_def_src(cfg_def_src),
      .posc_xtal(posc_xtal), .wr_req(wr_req), .req_wdata(req_wdata),
      .start_set(start_set), .fail_evt(fail_evt), .ost_done(ost_done),
      .pll_lock(pll_lock), .wdt_fscm_on(wdt_fscm_on), .sosc_keep(sosc_keep),
      .pend_clk(pend_clk), .req_src(req_src), .start_bit(start_bit),
      .cur_src(cur_src), .pend_sel(pend_sel), .lock_stat(lock_stat),
      .fail_stat(fail_stat), .osc_en(osc_en), .pll_en(pll_en)
   );

   function automatic bit is_pll(logic [2:0] c);
      return c == 3'b001 || c == 3'b011;
   endfunction
   function automatic bit legal(logic [2:0] cur, logic [2:0] req);
      return req <= 3'b101 && req != cur && !(is_pll(cur) && is_pll(req));
   endfunction
   function automatic bit needs_ost(logic [2:0] c, bit xtal);
      return c == 3'b100 || (xtal && (c == 3'b010 || c == 3'b011));
   endfunction
   function automatic int osc_idx(logic [2:0] c);
      return (c <= 3'b001) ? 0 : (c <= 3'b011) ? 1 : (c == 3'b100) ? 2 : 3;
   endfunction
   function automatic logic [3:0] exp_en(logic [2:0] c, bit wdt, bit keep);
      logic [3:0] e = 4'b0;
      e[osc_idx(c)] = 1'b1;
      if (wdt)  e[3] = 1'b1;
      if (keep) e[2] = 1'b1;
      return e;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic do_switch(logic [2:0] req, int delay, bit pulse_fail);
      logic [2:0] pre = cur_model;
      bit wait_rdy;
      int t;
      repeat (12) tick();
      ost_done = 1'b0; pll_lock = 1'b0;
      if (pulse_fail) begin
         fail_evt = 1'b1; tick(); fail_evt = 1'b0;
         check(fail_stat == 1'b1, "R6 fail set", fail_stat, 1);
      end
      wr_req = 1'b1; req_wdata = req; tick(); wr_req = 1'b0;
      start_set = 1'b1; tick(); start_set = 1'b0;
      check(start_bit == 1'b1, "R3 start set", start_bit, 1);
      if (!legal(pre, req)) begin
         tick();
         if (req == pre)
            check(start_bit == 1'b0, "R3 redundant drop", start_bit, 0);
         else if (req > 3'b101)
            check(start_bit == 1'b0, "R4 reserved drop", start_bit, 0);
         else
            check(start_bit == 1'b0, "R5 pll cross drop", start_bit, 0);
         check(cur_src == pre, "R3 R4 R5 source kept", cur_src, pre);
         return;
      end
      wait_rdy = needs_ost(req, posc_xtal) || is_pll(req);
      if (wait_rdy) begin
         repeat (delay + 3) tick();
         check(cur_src == pre, "R8 held while waiting", cur_src, pre);
         check(lock_stat == 1'b0 && fail_stat == 1'b0, "R6 status cleared",
               {lock_stat, fail_stat}, 0);
         check(osc_en[osc_idx(req)] == 1'b1, "R7 target enabled", osc_en, osc_idx(req));
         check(pll_en == is_pll(req) || is_pll(pre), "R7 pll enable", pll_en, is_pll(req));
         ost_done = 1'b1; pll_lock = 1'b1;
      end
      pend_cnt = 0; counting = 1'b1;
      t = 0;
      while (start_bit && t < 1000) begin tick(); t++; end
      counting = 1'b0;
      check(cur_src == req, "R9 new source", cur_src, req);
      check(pend_cnt >= SETTLE, "R9 settle edges", pend_cnt, SETTLE);
      tick();
      check(osc_en == exp_en(req, wdt_fscm_on, sosc_keep), "R10 enables after switch",
            osc_en, exp_en(req, wdt_fscm_on, sosc_keep));
      if (is_pll(req)) check(lock_stat == 1'b1, "R11 lock status", lock_stat, 1);
      cur_model = req;
   endtask

   initial begin
      int unsigned s;
      s = $urandom(32'h5eed_c1c5);
      repeat (3) tick();
      check(cur_src == 3'b000 && start_bit == 1'b0, "R1 reset source", cur_src, 0);
      check(lock_stat == 1'b0 && fail_stat == 1'b0, "R1 reset status", {lock_stat, fail_stat}, 0);
      rst_n = 1'b1;
      tick();
      check(cur_src == 3'b000 && start_bit == 1'b0, "R1 after reset", cur_src, 0);
      check(osc_en == 4'b0001, "R10 reset enables", osc_en, 1);

      do_switch(3'b000, 0, 1'b0);
      do_switch(3'b110, 0, 1'b0);
      do_switch(3'b111, 0, 1'b0);
      do_switch(3'b001, 2, 1'b1);
      do_switch(3'b011, 0, 1'b0);
      do_switch(3'b000, 0, 1'b0);
      do_switch(3'b011, 4, 1'b1);
      do_switch(3'b001, 0, 1'b0);
      do_switch(3'b000, 0, 1'b0);
      posc_xtal = 1'b1;
      do_switch(3'b010, 5, 1'b0);
      wdt_fscm_on = 1'b1; sosc_keep = 1'b1;
      do_switch(3'b100, 3, 1'b0);
      do_switch(3'b000, 0, 1'b0);
      sosc_keep = 1'b0;
      do_switch(3'b101, 0, 1'b0);
      do_switch(3'b000, 0, 1'b0);

      // R2: disabled switching pins the source to the default
      repeat (12) tick();
      cfg_def_src = 3'b010; cfg_sw_dis = 1'b1;
      tick();
      check(cur_src == 3'b010, "R2 default shown", cur_src, 2);
      wr_req = 1'b1; req_wdata = 3'b100; tick(); wr_req = 1'b0;
      start_set = 1'b1; tick(); start_set = 1'b0;
      check(start_bit == 1'b0, "R2 start forced low", start_bit, 0);
      repeat (40) tick();
      check(cur_src == 3'b010, "R2 request ignored", cur_src, 2);
      cfg_sw_dis = 1'b0; cur_model = 3'b010;
      tick();

      for (int i = 0; i < 40; i++) begin
         wdt_fscm_on = 1'($urandom % 2);
         sosc_keep   = 1'($urandom % 2);
         posc_xtal   = 1'($urandom % 2);
         do_switch(3'($urandom % 8), int'($urandom % 6), 1'($urandom % 2));
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule